// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block produces three complementary pairs of gate-drive signals (high and low side for phases A, B and C) for a three-phase inverter. A single up/down counter runs from the period value minus one down to zero and back up again. Each phase compares the count against its own duty value, so every pulse is centred on the middle of the switching period. A programmable dead gap separates the high-side and low-side edges of a pair. A programmable minimum width removes any pulse that would be narrower than the power stage can handle.

Software writes registers through a one-cycle write strobe with a 3-bit address. Every write goes into a shadow copy. Shadow copies move into the working set at the start of each period. In double update mode the duty values are also copied at the period midpoint, so the two halves of a pulse can differ. A sync pulse marks the start of every period. A trip input forces all six outputs low at once, and the shutdown stays latched until software clears it. Output steering, crossover and gate chopping happen in a separate block downstream.

Top module: `pwm3_center`

## Requirements
- R1: The period register (address 0) sets P. The period lasts 2·P clock cycles, counted from one sync rising edge to the next. A write during a period does not change the length of that period.
- R2: The duty registers (addresses 4, 5, 6 for phases A, B, C) set D. Let h = max(D − ⌊DT/2⌋, 0). In each half period the high side is on for min(h, P) cycles and the low side for max(P − h − DT, 0) cycles. Both pulses are centred on the counter's turning points.
- R3: The dead-time register (address 1) sets DT. A high side and its low side are never on together. When both pulses exist, the pair is off for DT cycles at each edge.
- R4: The minimum-width register (address 2) sets M. A high or low pulse whose full-period width would be under M cycles (twice its per-half on-time) is removed.
- R5: Writes reach shadow registers only. In single update mode (address 7 bit 0 = 0) new values take effect at the first cycle of the next period.
- R6: In double update mode (address 7 bit 0 = 1) the duty shadows are also loaded at the period midpoint. The second half then uses duty values written during the first half.
- R7: The sync output goes high in the first cycle of each period and stays high for SW+1 cycles. SW is the sync-width register (address 3).
- R8: While the trip input is high, all six outputs are low in the same cycle. No clock edge is needed.
- R9: A trip latches the shutdown after two synchronising stages. Writing address 7 with bit 1 set clears the latch. Outputs stay low until the next period start after the clear.
- R10: After reset all registers are zero and all six outputs are low. With P = 0, no output turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW (16) | Write data |
| trip | input | 1 | Asynchronous shutdown request, active high |
| ah | output | 1 | Phase A high side |
| al | output | 1 | Phase A low side |
| bh | output | 1 | Phase B high side |
| bl | output | 1 | Phase B low side |
| ch | output | 1 | Phase C high side |
| cl | output | 1 | Phase C low side |
| sync_out | output | 1 | Period start pulse |

## Verification
Almost every internal fault in this block changes a pulse width or the spacing between sync edges. Such faults therefore show up within one switching period.
- A counter that turns one step early or late, or a period loaded at the wrong moment, changes the distance between sync rising edges in the first affected period.
- A wrong threshold, dead-time split or minimum-width comparison changes the on-time totals of one pair in the same period.
- A shadow register copied at the wrong point shows in the period during which it was written, because that period is compared against the old values.
- A trip latch that does not hold, or a hold that ends at the wrong moment, shows as an output turning on in the cycles between trip release and the next period start.

// File: rtl/pwm3_center.sv
module pwm3_center #(
  parameter int CW  = 16,
  parameter int DTW = 10,
  parameter int SWW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trip,
  output logic          ah,
  output logic          al,
  output logic          bh,
  output logic          bl,
  output logic          ch,
  output logic          cl,
  output logic          sync_out
);
  localparam int XW = CW + 1;

  logic [CW-1:0]  per_s, per_a, cnt;
  logic [DTW-1:0] dt_s, dt_a, mpw_s, mpw_a;
  logic [SWW-1:0] sw_s;
  logic [SWW:0]   sc;
  logic [CW-1:0]  duty_s [3];
  logic [CW-1:0]  duty_a [3];
  logic           dbl_s, dbl_a, up;
  logic           trip_m, trip_s, trip_lat, hold;
  logic           top, mid, clr, off;
  logic [2:0]     hi, lo;

  assign top = up && (XW'(cnt) + XW'(1) >= XW'(per_a));
  assign mid = !up && (cnt == '0);
  assign clr = wr_en && (wr_addr == 3'd7) && wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_s <= '0; dt_s <= '0; mpw_s <= '0; sw_s <= '0; dbl_s <= 1'b0;
      for (int i = 0; i < 3; i++) duty_s[i] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: per_s     <= wr_data;
        3'd1: dt_s      <= wr_data[DTW-1:0];
        3'd2: mpw_s     <= wr_data[DTW-1:0];
        3'd3: sw_s      <= wr_data[SWW-1:0];
        3'd4: duty_s[0] <= wr_data;
        3'd5: duty_s[1] <= wr_data;
        3'd6: duty_s[2] <= wr_data;
        default: dbl_s  <= wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_a <= '0; dt_a <= '0; mpw_a <= '0; dbl_a <= 1'b0;
      for (int i = 0; i < 3; i++) duty_a[i] <= '0;
    end else if (top) begin
      per_a <= per_s; dt_a <= dt_s; mpw_a <= mpw_s; dbl_a <= dbl_s;
      for (int i = 0; i < 3; i++) duty_a[i] <= duty_s[i];
    end else if (mid && dbl_a) begin
      for (int i = 0; i < 3; i++) duty_a[i] <= duty_s[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (top) begin
      cnt <= (per_s == '0) ? '0 : per_s - 1'b1;
      up  <= 1'b0;
    end else if (mid) begin
      up <= 1'b1;
    end else if (up) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sc <= '0;
    else if (top)      sc <= {1'b0, sw_s} + 1'b1;
    else if (sc != '0) sc <= sc - 1'b1;
  end
  assign sync_out = (sc != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_m <= 1'b0; trip_s <= 1'b0; trip_lat <= 1'b0; hold <= 1'b0;
    end else begin
      trip_m <= trip;
      trip_s <= trip_m;
      if (trip_s)   trip_lat <= 1'b1;
      else if (clr) trip_lat <= 1'b0;
      if (clr)      hold <= 1'b1;
      else if (top) hold <= 1'b0;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_ph
    logic [CW-1:0] half, hth;
    logic [XW-1:0] lth, hwid, lwid;
    assign half = CW'(dt_a >> 1);
    assign hth  = (duty_a[g] > half) ? duty_a[g] - half : '0;
    assign lth  = XW'(hth) + XW'(dt_a);
    assign hwid = (hth < per_a) ? XW'(hth) : XW'(per_a);
    assign lwid = (lth >= XW'(per_a)) ? '0 : XW'(per_a) - lth;
    assign hi[g] = (cnt < hth) && (cnt < per_a) && ((hwid << 1) >= XW'(mpw_a));
    assign lo[g] = (XW'(cnt) >= lth) && (cnt < per_a) && ((lwid << 1) >= XW'(mpw_a));
  end

  assign off = trip | trip_lat | hold;
  assign ah = hi[0] & ~off;
  assign al = lo[0] & ~off;
  assign bh = hi[1] & ~off;
  assign bl = lo[1] & ~off;
  assign ch = hi[2] & ~off;
  assign cl = lo[2] & ~off;

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (per_a != '0) |-> (cnt < per_a));
  p_pair_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ah && al) && !(bh && bl) && !(ch && cl));
  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !top |=> $stable(per_a));
  p_mid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!top && !(mid && dbl_a)) |=> $stable(duty_a[0]));
  p_sync_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    top |=> sync_out);
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !top) |=> !(ah || al || bh || bl || ch || cl));
endmodule

// File: tb/pwm3_center_bench.sv
`timescale 1ns/1ps
module pwm3_center_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trip = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ah, al, bh, bl, ch, cl, sync_out;

  pwm3_center u_pwm3_center (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip(trip), .ah(ah), .al(al), .bh(bh), .bl(bl), .ch(ch), .cl(cl),
    .sync_out(sync_out));

  always #10 clk = ~clk;

  typedef struct {
    string tag;
    int len, sw;
    int h0, h1, h2, l0, l1, l2;
  } item_t;

  item_t q[$];
  item_t cur;
  int vectors = 0, miscomp = 0;
  event period_start;
  bit pend = 0;
  logic sync_q = 1'b0;
  int len, sc, hc[3], lc[3];
  bit ovl;
  logic [2:0] hv, lv;
  assign hv = {ch, bh, ah};
  assign lv = {cl, bl, al};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hw(int p, int dt, int m, int d);
    int h;
    h = (d > dt / 2) ? d - dt / 2 : 0;
    if (h > p) h = p;
    if (2 * h < m) h = 0;
    return h;
  endfunction

  function automatic int lw(int p, int dt, int m, int d);
    int h, l;
    h = (d > dt / 2) ? d - dt / 2 : 0;
    l = h + dt;
    l = (l >= p) ? 0 : p - l;
    if (2 * l < m) l = 0;
    return l;
  endfunction

  function automatic item_t mk(string tag, int p, int dt, int m, int sw,
                               int a0, int a1, int b0, int b1, int c0, int c1);
    item_t it;
    it.tag = tag; it.len = 2 * p; it.sw = sw + 1;
    it.h0 = hw(p, dt, m, a0) + hw(p, dt, m, a1);
    it.h1 = hw(p, dt, m, b0) + hw(p, dt, m, b1);
    it.h2 = hw(p, dt, m, c0) + hw(p, dt, m, c1);
    it.l0 = lw(p, dt, m, a0) + lw(p, dt, m, a1);
    it.l1 = lw(p, dt, m, b0) + lw(p, dt, m, b1);
    it.l2 = lw(p, dt, m, c0) + lw(p, dt, m, c1);
    return it;
  endfunction

  task automatic compare();
    int eh[3], el[3];
    eh = '{cur.h0, cur.h1, cur.h2};
    el = '{cur.l0, cur.l1, cur.l2};
    chk(len == cur.len, "R1 period length", len, cur.len);
    chk(sc == cur.sw, "R7 sync width", sc, cur.sw);
    chk(!ovl, "R3 pair overlap", ovl, 0);
    for (int k = 0; k < 3; k++) begin
      chk(hc[k] == eh[k], $sformatf("%s high phase %0d", cur.tag, k), hc[k], eh[k]);
      chk(lc[k] == el[k], $sformatf("%s low phase %0d", cur.tag, k), lc[k], el[k]);
      chk(len - hc[k] - lc[k] == cur.len - eh[k] - el[k],
          $sformatf("R3 dead cycles phase %0d", k),
          len - hc[k] - lc[k], cur.len - eh[k] - el[k]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sync_out && !sync_q) begin
        if (pend) compare();
        pend = (q.size() > 0);
        if (pend) cur = q.pop_front();
        len = 0; sc = 0; ovl = 0;
        for (int k = 0; k < 3; k++) begin hc[k] = 0; lc[k] = 0; end
        -> period_start;
      end
      len++;
      if (sync_out) sc++;
      for (int k = 0; k < 3; k++) begin
        hc[k] += int'(hv[k]);
        lc[k] += int'(lv[k]);
      end
      if ((hv & lv) != 3'b000) ovl = 1;
      sync_q = sync_out;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog expired (R1 period never completed) actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state, period zero
    repeat (6) begin
      @(negedge clk); #1;
      chk({ah, al, bh, bl, ch, cl} == 6'b0, "R10 outputs off after reset",
          int'({ah, al, bh, bl, ch, cl}), 0);
    end

    // R2 and R3: nominal pattern
    wr(0, 20); wr(1, 4); wr(2, 0); wr(3, 2);
    wr(4, 10); wr(5, 5); wr(6, 15); wr(7, 0);
    @(period_start);
    q.push_back(mk("R2", 20, 4, 0, 2, 10, 10, 5, 5, 15, 15));
    @(period_start); @(period_start);

    // R2: zero dead time, duty at 0 and at the period value
    wr(1, 0); wr(4, 0); wr(5, 20); wr(6, 7);
    @(period_start);
    q.push_back(mk("R2", 20, 0, 0, 2, 0, 0, 20, 20, 7, 7));
    @(period_start); @(period_start);

    // R4: narrow pulse removal
    wr(1, 4); wr(2, 6); wr(4, 3); wr(5, 18); wr(6, 17);
    @(period_start);
    q.push_back(mk("R4", 20, 4, 6, 2, 3, 3, 18, 18, 17, 17));
    @(period_start); @(period_start);

    // R5: write during a period only applies from the next one
    q.push_back(mk("R5", 20, 4, 6, 2, 3, 3, 18, 18, 17, 17));
    @(period_start);
    wr(4, 12);
    q.push_back(mk("R5", 20, 4, 6, 2, 12, 12, 18, 18, 17, 17));
    @(period_start); @(period_start);

    // R6: double update, second half takes the new duty
    wr(7, 1); wr(2, 0);
    @(period_start);
    q.push_back(mk("R6", 20, 4, 0, 2, 12, 8, 18, 18, 17, 17));
    @(period_start);
    wr(4, 8);
    @(period_start);

    // R1 and R7: new period, shortest sync
    wr(0, 25); wr(3, 0);
    @(period_start);
    q.push_back(mk("R1", 25, 4, 0, 0, 8, 8, 18, 18, 17, 17));
    @(period_start); @(period_start);

    // R8: trip forces outputs off at once
    @(period_start);
    repeat (5) @(negedge clk);
    trip = 1'b1;
    #1 chk({ah, al, bh, bl, ch, cl} == 6'b0, "R8 trip immediate",
           int'({ah, al, bh, bl, ch, cl}), 0);
    repeat (4) begin
      @(negedge clk); #1;
      chk({ah, al, bh, bl, ch, cl} == 6'b0, "R8 trip held",
          int'({ah, al, bh, bl, ch, cl}), 0);
    end
    trip = 1'b0;
    // R9: shutdown stays latched after trip release
    repeat (5) begin
      @(negedge clk); #1;
      chk({ah, al, bh, bl, ch, cl} == 6'b0, "R9 latched after release",
          int'({ah, al, bh, bl, ch, cl}), 0);
    end
    q.push_back(mk("R9", 25, 4, 0, 0, 8, 8, 18, 18, 17, 17));
    wr(7, 3);
    begin
      bit seen;
      logic prv;
      int bad;
      seen = 0; bad = 0; prv = sync_out;
      while (!seen) begin
        @(negedge clk); #1;
        if (sync_out && !prv) seen = 1;
        else if ({ah, al, bh, bl, ch, cl} != 6'b0) bad++;
        prv = sync_out;
      end
      chk(bad == 0, "R9 off until next period start", bad, 0);
    end
    @(negedge clk);
    @(period_start);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule